// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry Unit

This unit sits beside a processor's instruction sequencer and decides, at each instruction boundary, whether to start an interrupt. There are two kinds of request. The first is a non-maskable request, raised by an edge on a dedicated pin. The second is a general request, which arrives as an encoded priority level together with an event code. When a request is accepted, the unit performs the whole exception entry in a single clock. It saves the program counter, the status word and the stack pointer (R15) into three save registers. It loads an event code, raises the privilege, bank and block bits in the status word, and sets the new program counter to the vector base plus 0x600.

The control path is a two-state machine. In `ST_RUN` the unit watches the boundary strobe and evaluates both kinds of request. The transition `RUN_TO_TAKEN` fires when either kind is acceptable at a boundary, and the entry registers update on that same edge. `ST_TAKEN` lasts exactly one cycle and drives the `taken` pulse. Its only transition, `TAKEN_TO_RUN`, is unconditional. The sequencer is expected to resume fetching from `pc_out` and to feed the updated status word back on `sr_in`.

Top module: `irq_entry_top`

## Requirements
- R1: A rising edge on `nmi_pin` (low in one sampled cycle, high in the next) latches a pending non-maskable request. A pin held high does not request again. The pin history resets to low, so a pin that is already high when reset is released counts as one edge.
- R2: On any entry, `pc_out` becomes `vbr_in + 0x600`.
- R3: On any entry, `spc_out`, `ssr_out` and `sgr_out` take the values of `pc_in`, `sr_in` and `r15_in` at the accepting edge.
- R4: A non-maskable entry loads `evt_out` with 0x000001C0. A general entry loads `evt_out` with `irq_code` zero-extended to 32 bits.
- R5: On any entry, `sr_out` equals `sr_in` with bit 30 (privilege), bit 29 (bank) and bit 28 (block, BL) set to 1.
- R6: With BL=0, a pending non-maskable request is taken at a boundary whatever the mask field `sr_in[7:4]` holds. When both kinds are acceptable, the non-maskable request wins.
- R7: With BL=1, a pending non-maskable request is held while `nmi_bl_accept`=0 and is taken at a boundary while `nmi_bl_accept`=1.
- R8: On a non-maskable entry with `nmi_mask_force`=1, `sr_out[7:4]` becomes 0xF. In every other entry the mask field is copied unchanged from `sr_in`.
- R9: A general request is taken only when `boundary`=1, BL=0 and `irq_level` is strictly greater than `sr_in[7:4]`.
- R10: The pending non-maskable request clears on its entry edge. Further edges that arrive while it is pending, including one in the entry cycle, merge into it and cause no second entry.
- R11: `taken` is high for exactly one cycle, the cycle after the accepting edge. The entry outputs change only at that edge, and no request is accepted while `taken` is high.
- R12: After reset, all outputs are zero and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Non-maskable request pin, edge sensitive |
| boundary | input | 1 | High in cycles that are instruction boundaries |
| irq_level | input | 4 | Priority level of the general request, 0 means none |
| irq_code | input | 12 | Event code of the general request |
| nmi_bl_accept | input | 1 | With BL=1: 1 accepts the non-maskable request, 0 holds it |
| nmi_mask_force | input | 1 | Forces the mask field to all ones on non-maskable entry |
| sr_in | input | 32 | Current status word |
| pc_in | input | 32 | Program counter to resume at after the handler |
| r15_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector base address |
| taken | output | 1 | One-cycle pulse marking an entry |
| spc_out | output | 32 | Saved program counter |
| ssr_out | output | 32 | Saved status word |
| sgr_out | output | 32 | Saved stack pointer |
| evt_out | output | 32 | Event code of the last entry |
| sr_out | output | 32 | Status word after entry |
| pc_out | output | 32 | New program counter |

## Verification
The bench targets the mask comparison at the boundary where `irq_level` equals the mask, which must not be accepted. A design that used greater-or-equal would enter one level too early. It also targets a simultaneous non-maskable and general request: a design with the wrong priority would report the general code in place of 0x1C0. Repeated edges while a request is pending, and a pin held high, are driven to expose a design that enters twice or re-triggers on level. Block-bit cases with and without the accept control, and the forced mask, catch a design that ignores BL or always forces the mask field. This includes general entries with the force bit set, where the field must stay unchanged.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // Status word bit positions the entry logic reads or writes
    localparam int SR_PRIV_BIT  = 30;
    localparam int SR_BANK_BIT  = 29;
    localparam int SR_BLOCK_BIT = 28;
    localparam int SR_MASK_LSB  = 4;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_TAKEN = 1'b1
    } entry_state_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_NMI  = 2'd1,
        KIND_IRQ  = 2'd2
    } entry_kind_e;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
    parameter bit NMI_RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic accept,
    output logic pending
);

    localparam logic PIN_IDLE = ~NMI_RISING;

    logic pin_q;
    logic edge_seen;

    generate
        if (NMI_RISING) begin : g_rise
            assign edge_seen = nmi_pin & ~pin_q;
        end else begin : g_fall
            assign edge_seen = ~nmi_pin & pin_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= PIN_IDLE;
            pending <= 1'b0;
        end else begin
            pin_q <= nmi_pin;
            if (accept) begin
                pending <= 1'b0;
            end else if (edge_seen) begin
                pending <= 1'b1;
            end
        end
    end

    // R10: acceptance empties the latch on the next cycle
    a_r10_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !pending);

    // R1: a rising pin not being accepted leaves a pending request
    a_r1_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (NMI_RISING && $rose(nmi_pin) && !accept) |=> pending);

endmodule

// File: rtl/irq_accept_fsm.sv
module irq_accept_fsm
    import irq_entry_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             nmi_pending,
    input  logic             nmi_bl_accept,
    input  logic             sr_block,
    input  logic [LVL_W-1:0] sr_mask,
    input  logic [LVL_W-1:0] irq_level,
    output entry_kind_e      take_kind,
    output logic             taken
);

    entry_state_e state_q;
    entry_state_e state_d;
    logic         nmi_ok;
    logic         irq_ok;

    assign nmi_ok = nmi_pending & (~sr_block | nmi_bl_accept);
    assign irq_ok = ~sr_block & (irq_level > sr_mask);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and entry decision
    always_comb begin
        state_d   = state_q;
        take_kind = KIND_NONE;
        unique case (state_q)
            ST_RUN: begin
                if (boundary && nmi_ok) begin
                    take_kind = KIND_NMI;
                    state_d   = ST_TAKEN;
                end else if (boundary && irq_ok) begin
                    take_kind = KIND_IRQ;
                    state_d   = ST_TAKEN;
                end
            end
            ST_TAKEN: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Outputs
    always_comb begin
        taken = (state_q == ST_TAKEN);
    end

    // R11: nothing is accepted during the pulse cycle
    a_r11_no_take_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (take_kind == KIND_NONE));

    // R9: a general entry needs a boundary, BL clear and a level above the mask
    a_r9_irq_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        (take_kind == KIND_IRQ) |-> (boundary && !sr_block && (irq_level > sr_mask)));

    // R6: a general entry never hides an acceptable non-maskable request
    a_r6_nmi_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (take_kind == KIND_IRQ) |-> !nmi_pending);

endmodule

// File: rtl/irq_state_update.sv
module irq_state_update
    import irq_entry_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              LVL_W      = 4,
    parameter int              CODE_W     = 12,
    parameter logic [XLEN-1:0] VEC_OFFSET = 32'h0000_0600,
    parameter logic [XLEN-1:0] NMI_CODE   = 32'h0000_01C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  entry_kind_e       take_kind,
    input  logic              nmi_mask_force,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic [CODE_W-1:0] irq_code,
    output logic [XLEN-1:0]   spc_out,
    output logic [XLEN-1:0]   ssr_out,
    output logic [XLEN-1:0]   sgr_out,
    output logic [XLEN-1:0]   evt_out,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   pc_out
);

    localparam int PAD_W = XLEN - CODE_W;

    logic [XLEN-1:0] sr_entry;
    logic [XLEN-1:0] evt_entry;
    logic            do_entry;

    assign do_entry = (take_kind != KIND_NONE);

    always_comb begin
        sr_entry               = sr_in;
        sr_entry[SR_PRIV_BIT]  = 1'b1;
        sr_entry[SR_BANK_BIT]  = 1'b1;
        sr_entry[SR_BLOCK_BIT] = 1'b1;
        if ((take_kind == KIND_NMI) && nmi_mask_force) begin
            sr_entry[SR_MASK_LSB +: LVL_W] = '1;
        end
    end

    always_comb begin
        if (take_kind == KIND_NMI) begin
            evt_entry = NMI_CODE;
        end else begin
            evt_entry = {{PAD_W{1'b0}}, irq_code};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spc_out <= '0;
            ssr_out <= '0;
            sgr_out <= '0;
            evt_out <= '0;
            sr_out  <= '0;
            pc_out  <= '0;
        end else if (do_entry) begin
            spc_out <= pc_in;
            ssr_out <= sr_in;
            sgr_out <= r15_in;
            evt_out <= evt_entry;
            sr_out  <= sr_entry;
            pc_out  <= vbr_in + VEC_OFFSET;
        end
    end

    // R3: the three save registers capture the entry-cycle inputs
    a_r3_saved_state: assert property (@(posedge clk) disable iff (!rst_n)
        do_entry |=> (spc_out == $past(pc_in)) && (ssr_out == $past(sr_in))
                     && (sgr_out == $past(r15_in)));

    // R2: vector address
    a_r2_vector: assert property (@(posedge clk) disable iff (!rst_n)
        do_entry |=> (pc_out == $past(vbr_in) + VEC_OFFSET));

    // R5: privilege, bank and block bits raised
    a_r5_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        do_entry |=> (sr_out[SR_PRIV_BIT] && sr_out[SR_BANK_BIT] && sr_out[SR_BLOCK_BIT]));

    // R8: forced mask on non-maskable entry
    a_r8_mask_forced: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_kind == KIND_NMI) && nmi_mask_force) |=> (sr_out[SR_MASK_LSB +: LVL_W] == '1));

    // R4: fixed code for non-maskable entry
    a_r4_nmi_code: assert property (@(posedge clk) disable iff (!rst_n)
        (take_kind == KIND_NMI) |=> (evt_out == NMI_CODE));

endmodule

// File: rtl/irq_entry_top.sv
module irq_entry_top
    import irq_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int LVL_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic              boundary,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              nmi_bl_accept,
    input  logic              nmi_mask_force,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    output logic              taken,
    output logic [XLEN-1:0]   spc_out,
    output logic [XLEN-1:0]   ssr_out,
    output logic [XLEN-1:0]   sgr_out,
    output logic [XLEN-1:0]   evt_out,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   pc_out
);

    entry_kind_e take_kind;
    logic        nmi_pending;
    logic        nmi_accept;

    assign nmi_accept = (take_kind == KIND_NMI);

    irq_nmi_latch #(
        .NMI_RISING (1'b1)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_pin (nmi_pin),
        .accept  (nmi_accept),
        .pending (nmi_pending)
    );

    irq_accept_fsm #(
        .LVL_W (LVL_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .boundary      (boundary),
        .nmi_pending   (nmi_pending),
        .nmi_bl_accept (nmi_bl_accept),
        .sr_block      (sr_in[SR_BLOCK_BIT]),
        .sr_mask       (sr_in[SR_MASK_LSB +: LVL_W]),
        .irq_level     (irq_level),
        .take_kind     (take_kind),
        .taken         (taken)
    );

    irq_state_update #(
        .XLEN   (XLEN),
        .LVL_W  (LVL_W),
        .CODE_W (CODE_W)
    ) u_update (
        .clk            (clk),
        .rst_n          (rst_n),
        .take_kind      (take_kind),
        .nmi_mask_force (nmi_mask_force),
        .pc_in          (pc_in),
        .sr_in          (sr_in),
        .r15_in         (r15_in),
        .vbr_in         (vbr_in),
        .irq_code       (irq_code),
        .spc_out        (spc_out),
        .ssr_out        (ssr_out),
        .sgr_out        (sgr_out),
        .evt_out        (evt_out),
        .sr_out         (sr_out),
        .pc_out         (pc_out)
    );

    // R11: the pulse is a single cycle
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !taken);

    // R11: entry outputs hold outside the pulse cycle
    a_r11_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> ($stable(spc_out) && $stable(sr_out) && $stable(pc_out) && $stable(evt_out)));

endmodule

// File: tb/sim_irq_entry_top.sv
`timescale 1ns/1ps
module sim_irq_entry_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 1'b0;
    logic        boundary = 1'b0;
    logic [3:0]  irq_level = '0;
    logic [11:0] irq_code = '0;
    logic        nmi_bl_accept = 1'b0;
    logic        nmi_mask_force = 1'b0;
    logic [31:0] sr_in = '0;
    logic [31:0] pc_in = '0;
    logic [31:0] r15_in = '0;
    logic [31:0] vbr_in = '0;
    logic        taken;
    logic [31:0] spc_out, ssr_out, sgr_out, evt_out, sr_out, pc_out;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference state
    bit          m_prev, m_pend, m_taken;
    logic [31:0] m_spc, m_ssr, m_sgr, m_evt, m_sr, m_pc;

    always #2.5 clk = ~clk;

    irq_entry_top u0 (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .boundary(boundary),
        .irq_level(irq_level), .irq_code(irq_code), .nmi_bl_accept(nmi_bl_accept),
        .nmi_mask_force(nmi_mask_force), .sr_in(sr_in), .pc_in(pc_in),
        .r15_in(r15_in), .vbr_in(vbr_in), .taken(taken), .spc_out(spc_out),
        .ssr_out(ssr_out), .sgr_out(sgr_out), .evt_out(evt_out),
        .sr_out(sr_out), .pc_out(pc_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] entry_sr(input logic [31:0] s, input bit nmi, input bit force_m);
        logic [31:0] r;
        r = s | 32'h7000_0000;
        if (nmi && force_m) r[7:4] = 4'hF;
        return r;
    endfunction

    task automatic model_edge();
        bit blk, tn, ti, edge_now;
        blk = sr_in[28];
        tn = !m_taken && boundary && m_pend && (!blk || nmi_bl_accept);
        ti = !m_taken && boundary && !tn && !blk && (irq_level > sr_in[7:4]);
        edge_now = nmi_pin && !m_prev;
        m_prev = nmi_pin;
        m_pend = tn ? 1'b0 : (m_pend || edge_now);
        if (tn || ti) begin
            m_spc = pc_in;
            m_ssr = sr_in;
            m_sgr = r15_in;
            m_pc  = vbr_in + 32'h600;
            m_sr  = entry_sr(sr_in, tn, nmi_mask_force);
            m_evt = tn ? 32'h1C0 : {20'd0, irq_code};
        end
        m_taken = tn || ti;
    endtask

    task automatic compare_all();
        chk("R11 taken", {31'd0, taken}, {31'd0, m_taken});
        chk("R3 spc", spc_out, m_spc);
        chk("R3 ssr", ssr_out, m_ssr);
        chk("R3 sgr", sgr_out, m_sgr);
        chk("R4 evt", evt_out, m_evt);
        chk("R5 R8 sr", sr_out, m_sr);
        chk("R2 pc", pc_out, m_pc);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R11 actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_prev = 0; m_pend = 0; m_taken = 0;
        m_spc = 0; m_ssr = 0; m_sgr = 0; m_evt = 0; m_sr = 0; m_pc = 0;
        pc_in = 32'h0000_1000; r15_in = 32'h8000_0F00; vbr_in = 32'h0C00_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk("R12 taken", {31'd0, taken}, 32'd0);
        chk("R12 pc", pc_out, 32'd0);
        chk("R12 evt", evt_out, 32'd0);
        chk("R12 sr", sr_out, 32'd0);

        // R9: level equal to mask is refused, above is accepted only at a boundary
        sr_in = 32'h0000_0050; irq_level = 4'd5; irq_code = 12'h3A0; boundary = 1'b1;
        cyc(); cyc();
        chk("R9 equal level", {31'd0, taken}, 32'd0);
        irq_level = 4'd6; boundary = 1'b0;
        cyc(); cyc();
        chk("R9 no boundary", {31'd0, taken}, 32'd0);
        boundary = 1'b1;
        cyc();
        chk("R9 taken", {31'd0, taken}, 32'd1);
        chk("R4 irq code", evt_out, 32'h0000_03A0);
        chk("R2 vector", pc_out, 32'h0C00_0600);
        boundary = 1'b0; irq_level = 4'd0;
        cyc();
        chk("R11 pulse ends", {31'd0, taken}, 32'd0);

        // R6: both acceptable, non-maskable wins; mask F ignored
        sr_in = 32'h0000_0030; irq_level = 4'd9; nmi_pin = 1'b1;
        cyc();
        boundary = 1'b1;
        cyc();
        chk("R6 priority", evt_out, 32'h0000_01C0);
        boundary = 1'b0; irq_level = 4'd0; nmi_pin = 1'b0;
        cyc();
        sr_in = 32'h0000_00F0; nmi_pin = 1'b1;
        cyc();
        boundary = 1'b1;
        cyc();
        chk("R6 mask ignored", {31'd0, taken}, 32'd1);
        nmi_pin = 1'b0; boundary = 1'b0;
        cyc();

        // R7 / R8: block bit held, then accepted with forced mask
        sr_in = 32'h1000_0020; nmi_bl_accept = 1'b0; nmi_mask_force = 1'b1;
        nmi_pin = 1'b1;
        cyc();
        boundary = 1'b1;
        cyc(); cyc(); cyc();
        chk("R7 held", {31'd0, taken}, 32'd0);
        nmi_bl_accept = 1'b1;
        cyc();
        chk("R7 accepted", {31'd0, taken}, 32'd1);
        chk("R8 forced mask", {28'd0, sr_out[7:4]}, 32'hF);
        // R1: pin stays high, no new request
        cyc(); cyc(); cyc();
        chk("R1 level no retrigger", {31'd0, taken}, 32'd0);
        boundary = 1'b0; nmi_pin = 1'b0; nmi_bl_accept = 1'b0;
        cyc();

        // R10: several edges while pending give one entry
        sr_in = 32'h0000_0000;
        nmi_pin = 1'b1; cyc(); nmi_pin = 1'b0; cyc();
        nmi_pin = 1'b1; cyc(); nmi_pin = 1'b0; cyc();
        boundary = 1'b1;
        cyc();
        chk("R10 one entry", {31'd0, taken}, 32'd1);
        cyc(); cyc(); cyc();
        chk("R10 merged", {31'd0, taken}, 32'd0);

        // R8: general entry with force bit keeps the mask
        sr_in = 32'h0000_0040; irq_level = 4'd7; irq_code = 12'h5C0;
        cyc();
        chk("R8 irq mask kept", {28'd0, sr_out[7:4]}, 32'h4);
        chk("R5 bits", {29'd0, sr_out[30:28]}, 32'h7);
        boundary = 1'b0; irq_level = 4'd0; nmi_mask_force = 1'b0;
        cyc();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] s;
            s = $urandom;
            if (($urandom % 10) < 7) s[28] = 1'b0;
            sr_in = s;
            if (($urandom % 6) == 0) nmi_pin = ~nmi_pin;
            boundary = ($urandom % 2) == 1;
            irq_level = 4'($urandom);
            irq_code = 12'($urandom);
            nmi_bl_accept = ($urandom % 2) == 1;
            nmi_mask_force = ($urandom % 2) == 1;
            pc_in = $urandom; r15_in = $urandom; vbr_in = $urandom;
            cyc();
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule